// File: doc/BRIEF.md
# Streaming Two-Point Pixel Corrector

This block sits in the readout path of a digitised image sensor and repairs each raw sample as it streams past in raster order. For every pixel it removes a stored dark level, then scales the result by a stored per-pixel gain so that all pixels share one response. Pixels marked as defective are not passed through. Each one is rebuilt from its corrected neighbours. The rebuild never depends only on pixels in the same row or the same column, so a whole dead row or a whole dead column can still be filled in.

Three small on-chip tables hold the calibration: the dark level, the gain and a defect flag for each pixel. Software loads them through a single write port between frames. The corrected stream leaves with the same valid, frame-start and line-end markers as the input. Every sample is delayed by the same fixed number of cycles, which is just over one line. A frame must be streamed with `in_valid` held high from its first pixel to its last. Frames may follow each other with or without idle cycles between them.

Top module: `pc_two_point_corr`

## Requirements
- R1: During and after reset, and before any input, `out_valid`, `out_sof` and `out_eol` are 0 and `out_data` is 0.
- R2: A pixel with a clear defect flag leaves as min(floor(max(raw - dark, 0) * gain / 2^14), 2^14 - 1). A raw value at or below its dark level gives 0.
- R3: The gain is unsigned with 2 integer bits and 14 fraction bits, so 0x4000 is unity. A product above 16383 saturates to 16383.
- R4: A flagged pixel that is neither first nor last in its row, and whose left and right neighbours are both unflagged, gets the floor of the mean of those two corrected neighbours.
- R5: Otherwise, a flagged pixel that is neither in the first nor in the last row, and whose upper and lower neighbours are both unflagged, gets the floor of the mean of those two corrected neighbours.
- R6: Otherwise a flagged pixel gets the most recent output value of an unflagged pixel, across frame boundaries. This value is 0 after reset.
- R7: Each output pixel appears COLS+2 clock edges after the edge that samples it. `out_valid`, `out_sof` and `out_eol` carry the input markers with the same delay.
- R8: A write on `cal_we` updates the table chosen by `cal_sel` at pixel index `cal_addr` (row*COLS + column): 0 selects the dark level (low 14 bits), 1 the gain (16 bits), 2 the defect flag (bit 0), 3 nothing. The write is dropped while `in_valid` is high, and from a frame's first pixel until its last pixel has been accepted.
- R9: A pixel with `in_sof` is row 0, column 0. `in_eol` ends a row, so the next pixel is column 0 of the next row, and back-to-back frames resynchronise on `in_sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Raw sample present |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eol | input | 1 | Sample is the last of its row |
| in_data | input | DW | Raw unsigned sample |
| cal_we | input | 1 | Calibration write strobe |
| cal_sel | input | 2 | Table select: 0 dark, 1 gain, 2 defect, 3 none |
| cal_addr | input | AW | Pixel index row*COLS+column |
| cal_wdata | input | GW | Write data |
| out_valid | output | 1 | Corrected sample present |
| out_sof | output | 1 | Delayed frame-start marker |
| out_eol | output | 1 | Delayed line-end marker |
| out_data | output | DW | Corrected sample |

## Verification
Each corrected sample is due COLS+2 edges after the edge that takes its raw value. The two markers are due in the same cycle as the sample. The bench timestamps every driven frame start and every observed output, and checks that the gap matches this latency. Each output is then matched by raster position against an arithmetic model, so a value arriving in a different cycle still lands in the right slot. All comparisons run only after the pipeline has fully drained. A write attempted during a frame is checked through the value that its target pixel produces later in the stream.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eol;
        logic good;
        logic rfirst;
        logic rlast;
        logic cfirst;
        logic clast;
    } pc_tag_t;

    typedef enum logic [1:0] {
        CAL_OFFSET = 2'd0,
        CAL_GAIN   = 2'd1,
        CAL_DEFECT = 2'd2,
        CAL_NONE   = 2'd3
    } pc_cal_sel_e;

endpackage

// File: rtl/pc_calib_mem.sv
module pc_calib_mem import pc_pkg::*; #(
    parameter int DW   = 14,
    parameter int GW   = 16,
    parameter int NPIX = 32,
    parameter int AW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [GW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_off,
    output logic [GW-1:0] rd_gain,
    output logic          rd_bad
);

    localparam logic [GW-1:0] ONE = GW'(1) << (GW-2);

    typedef struct packed {
        logic [NPIX-1:0][DW-1:0] off;
        logic [NPIX-1:0][GW-1:0] gain;
        logic [NPIX-1:0]         bad;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic wr_ok;

    always_comb begin
        tbl_d = tbl_q;
        wr_ok = wr_en && !busy && (int'(wr_addr) < NPIX);
        if (wr_ok) begin
            case (pc_cal_sel_e'(wr_sel))
                CAL_OFFSET: tbl_d.off[wr_addr]  = wr_data[DW-1:0];
                CAL_GAIN:   tbl_d.gain[wr_addr] = wr_data;
                CAL_DEFECT: tbl_d.bad[wr_addr]  = wr_data[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q.off  <= '0;
            tbl_q.gain <= {NPIX{ONE}};
            tbl_q.bad  <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_off  = tbl_q.off[rd_addr];
    assign rd_gain = tbl_q.gain[rd_addr];
    assign rd_bad  = tbl_q.bad[rd_addr];

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(tbl_q)) else $error("write taken while busy"); // R8

endmodule

// File: rtl/pc_gain_stage.sv
module pc_gain_stage import pc_pkg::*; #(
    parameter int DW = 14,
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_tag_t       in_tag,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] off,
    input  logic [GW-1:0] gain,
    output pc_tag_t       out_tag,
    output logic [DW-1:0] out_val
);

    localparam int PW = DW + GW;

    typedef struct packed {
        pc_tag_t       tag;
        logic [DW-1:0] val;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] diff;
    logic [PW-1:0] prod;
    logic [PW-1:0] scaled;

    always_comb begin
        diff   = (raw > off) ? (raw - off) : '0;
        prod   = PW'(diff) * PW'(gain);
        scaled = prod >> (GW - 2);
        st_d.tag = in_tag;
        st_d.val = (|scaled[PW-1:DW]) ? '1 : scaled[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_tag = st_q.tag;
    assign out_val = st_q.val;

    AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tag.vld && raw <= off) |=> (out_val == '0)) else $error("no clamp"); // R2

endmodule

// File: rtl/pc_subst.sv
module pc_subst import pc_pkg::*; #(
    parameter int DW   = 14,
    parameter int COLS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_tag_t       in_tag,
    input  logic [DW-1:0] in_val,
    output logic          out_vld,
    output logic          out_sof,
    output logic          out_eol,
    output logic [DW-1:0] out_data
);

    localparam int DEPTH = 2 * COLS + 1;
    localparam int TC    = COLS;
    localparam int TL    = COLS + 1;
    localparam int TR    = COLS - 1;
    localparam int TA    = 2 * COLS;
    localparam int TB    = 0;

    typedef struct packed {
        pc_tag_t [DEPTH-1:0]       tag;
        logic [DEPTH-1:0][DW-1:0]  val;
        logic [DW-1:0]             last_good;
        logic                      ovld;
        logic                      osof;
        logic                      oeol;
        logic [DW-1:0]             odata;
    } st_t;

    st_t st_d, st_q;
    pc_tag_t c;
    logic horiz_ok, vert_ok;
    logic [DW:0] hsum, vsum;

    always_comb begin
        st_d = st_q;
        st_d.tag[0] = in_tag;
        st_d.val[0] = in_val;
        for (int k = 1; k < DEPTH; k++) begin
            st_d.tag[k] = st_q.tag[k-1];
            st_d.val[k] = st_q.val[k-1];
        end
        c        = st_q.tag[TC];
        hsum     = {1'b0, st_q.val[TL]} + {1'b0, st_q.val[TR]};
        vsum     = {1'b0, st_q.val[TA]} + {1'b0, st_q.val[TB]};
        horiz_ok = !c.cfirst && !c.clast && st_q.tag[TL].good && st_q.tag[TR].good;
        vert_ok  = !c.rfirst && !c.rlast && st_q.tag[TA].good && st_q.tag[TB].good;
        st_d.ovld = c.vld;
        st_d.osof = c.vld && c.sof;
        st_d.oeol = c.vld && c.eol;
        if (c.vld) begin
            if (c.good) begin
                st_d.odata     = st_q.val[TC];
                st_d.last_good = st_q.val[TC];
            end else if (horiz_ok) begin
                st_d.odata = hsum[DW:1];
            end else if (vert_ok) begin
                st_d.odata = vsum[DW:1];
            end else begin
                st_d.odata = st_q.last_good;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.ovld;
    assign out_sof  = st_q.osof;
    assign out_eol  = st_q.oeol;
    assign out_data = st_q.odata;

    AST_GOOD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (c.vld && c.good) |=> (out_vld && out_data == $past(st_q.val[TC]))) else $error("good pixel altered"); // R2

    AST_LAST_GOOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(c.vld && c.good) |=> $stable(st_q.last_good)) else $error("fallback moved"); // R6

endmodule

// File: rtl/pc_two_point_corr.sv
module pc_two_point_corr import pc_pkg::*; #(
    parameter int DW   = 14,
    parameter int GW   = 16,
    parameter int COLS = 8,
    parameter int ROWS = 4,
    localparam int NPIX = COLS * ROWS,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [DW-1:0] in_data,
    input  logic          cal_we,
    input  logic [1:0]    cal_sel,
    input  logic [AW-1:0] cal_addr,
    input  logic [GW-1:0] cal_wdata,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eol,
    output logic [DW-1:0] out_data
);

    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic          in_frame;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [CW-1:0] cur_col;
    logic [RW-1:0] cur_row;
    logic [AW-1:0] pix_addr;
    logic          busy;
    pc_tag_t       tag_in, tag_s1;
    logic [DW-1:0] rd_off, val_s1;
    logic [GW-1:0] rd_gain;
    logic          rd_bad;

    always_comb begin
        pos_d   = pos_q;
        cur_col = in_sof ? '0 : pos_q.col;
        cur_row = in_sof ? '0 : pos_q.row;
        if (in_valid) begin
            if (in_eol) begin
                pos_d.col = '0;
                pos_d.row = cur_row + 1'b1;
            end else begin
                pos_d.col = cur_col + 1'b1;
                pos_d.row = cur_row;
            end
            pos_d.in_frame = !(in_eol && cur_row == LAST_ROW);
        end
        pix_addr = AW'(int'(cur_row) * COLS + int'(cur_col));
        busy     = in_valid || pos_q.in_frame;
        tag_in.vld    = in_valid;
        tag_in.sof    = in_sof;
        tag_in.eol    = in_eol;
        tag_in.good   = !rd_bad;
        tag_in.rfirst = (cur_row == '0);
        tag_in.rlast  = (cur_row == LAST_ROW);
        tag_in.cfirst = (cur_col == '0);
        tag_in.clast  = (cur_col == LAST_COL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    pc_calib_mem #(.DW(DW), .GW(GW), .NPIX(NPIX), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(cal_we), .busy(busy),
        .wr_sel(cal_sel), .wr_addr(cal_addr), .wr_data(cal_wdata),
        .rd_addr(pix_addr), .rd_off(rd_off), .rd_gain(rd_gain), .rd_bad(rd_bad)
    );

    pc_gain_stage #(.DW(DW), .GW(GW)) u_gain (
        .clk(clk), .rst_n(rst_n), .in_tag(tag_in), .raw(in_data),
        .off(rd_off), .gain(rd_gain), .out_tag(tag_s1), .out_val(val_s1)
    );

    pc_subst #(.DW(DW), .COLS(COLS)) u_subst (
        .clk(clk), .rst_n(rst_n), .in_tag(tag_s1), .in_val(val_s1),
        .out_vld(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    AST_MARKER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eol) |-> out_valid) else $error("stray marker"); // R7

    AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eol) |=> pos_q.in_frame) else $error("frame not open"); // R8

endmodule

// File: tb/pc_two_point_corr_tb.sv
module pc_two_point_corr_tb;

    localparam int DW   = 14;
    localparam int GW   = 16;
    localparam int COLS = 8;
    localparam int ROWS = 4;
    localparam int NPIX = COLS * ROWS;
    localparam int AW   = $clog2(NPIX);
    localparam int NFR  = 4;
    localparam int LAT  = COLS + 2;
    localparam int MAXV = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic cal_we = 1'b0;
    logic [1:0] cal_sel = '0;
    logic [AW-1:0] cal_addr = '0;
    logic [GW-1:0] cal_wdata = '0;
    logic out_valid, out_sof, out_eol;
    logic [DW-1:0] out_data;

    always #5 clk = ~clk;

    pc_two_point_corr #(.DW(DW), .GW(GW), .COLS(COLS), .ROWS(ROWS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_data(in_data), .cal_we(cal_we), .cal_sel(cal_sel),
        .cal_addr(cal_addr), .cal_wdata(cal_wdata), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int oidx = 0;
    int odat [NFR*NPIX];
    int osof [NFR*NPIX];
    int oeol [NFR*NPIX];
    int ocyc [NFR*NPIX];
    int icyc [NFR];
    int m_off [NPIX];
    int m_gain [NPIX];
    int m_bad [NPIX];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (oidx < NFR*NPIX) begin
                odat[oidx] = int'(out_data);
                osof[oidx] = int'(out_sof);
                oeol[oidx] = int'(out_eol);
                ocyc[oidx] = cyc;
            end
            oidx = oidx + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int raw_of(input int f, input int p);
        if (p % 7 == 3) return p;
        return (p * 523 + f * 977 + 1000) % (1 << DW);
    endfunction

    function automatic int corr_of(input int f, input int p);
        longint d;
        longint v;
        d = longint'(raw_of(f, p)) - longint'(m_off[p]);
        if (d < 0) d = 0;
        v = (d * longint'(m_gain[p])) >> (GW - 2);
        if (v > MAXV) v = MAXV;
        return int'(v);
    endfunction

    task automatic cal_write(input int sel, input int addr, input int data);
        @(negedge clk);
        cal_we = 1'b1; cal_sel = 2'(sel); cal_addr = AW'(addr); cal_wdata = GW'(data);
        @(negedge clk);
        cal_we = 1'b0;
    endtask

    task automatic send_frame(input int f, input bit attack);
        for (int p = 0; p < NPIX; p++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (p == 0);
            in_eol   = (p % COLS == COLS - 1);
            in_data  = DW'(raw_of(f, p));
            if (p == 0) icyc[f] = cyc;
            // R8: write attempt while streaming must be dropped
            if (attack && p == 12) begin
                cal_we = 1'b1; cal_sel = 2'd0; cal_addr = AW'(10); cal_wdata = GW'(MAXV);
            end else if (attack && p == 13) begin
                cal_we = 1'b1; cal_sel = 2'd1; cal_addr = AW'(10); cal_wdata = GW'(0);
            end else begin
                cal_we = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; cal_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lg;
        int corr [NPIX];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_sof after reset", int'(out_sof), 0);
        chk("R1", "out_eol after reset", int'(out_eol), 0);
        chk("R1", "out_data after reset", int'(out_data), 0);

        for (int p = 0; p < NPIX; p++) begin
            m_off[p]  = 50 + (p * 37) % 600;
            case (p % 4)
                0: m_gain[p] = 'h4000;
                1: m_gain[p] = 'h2000;
                2: m_gain[p] = 'hFFFF;
                default: m_gain[p] = 'h5A3C;
            endcase
            m_bad[p] = ((p / COLS) == 2 || (p % COLS) == 5 || p == 0 || p == NPIX - 1) ? 1 : 0;
            cal_write(0, p, m_off[p]);
            cal_write(1, p, m_gain[p]);
            cal_write(2, p, m_bad[p]);
        end
        cal_write(3, 4, 'h1234);   // R8: select 3 writes nothing

        send_frame(0, 1'b0);
        repeat (LAT + 4) @(negedge clk);
        send_frame(1, 1'b1);
        repeat (LAT + 4) @(negedge clk);
        cal_write(1, 9, 'hFFFF);
        m_gain[9] = 'hFFFF;
        cal_write(2, 0, 0);
        m_bad[0] = 0;
        // frames 2 and 3 back to back
        for (int p = 0; p < NPIX; p++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (p == 0); in_eol = (p % COLS == COLS - 1);
            in_data = DW'(raw_of(2, p));
            if (p == 0) icyc[2] = cyc;
        end
        send_frame(3, 1'b0);
        repeat (LAT + 6) @(negedge clk);

        chk("R7", "output count", oidx, NFR * NPIX);
        for (int f = 0; f < NFR; f++)
            chk("R7", $sformatf("latency frame %0d", f), ocyc[f*NPIX] - icyc[f], LAT + 1);

        // model: tables changed only between frames 1 and 2
        lg = 0;
        for (int f = 0; f < NFR; f++) begin
            int gain9;
            int bad0;
            gain9 = m_gain[9];
            bad0  = m_bad[0];
            if (f < 2) begin
                m_gain[9] = 'h2000;
                m_bad[0]  = 1;
            end
            for (int p = 0; p < NPIX; p++) corr[p] = corr_of(f, p);
            for (int p = 0; p < NPIX; p++) begin
                int r;
                int c;
                int ex;
                int i;
                string tag;
                r = p / COLS;
                c = p % COLS;
                i = f * NPIX + p;
                if (m_bad[p] == 0) begin
                    ex = corr[p];
                    lg = ex;
                    if (f == 1 && p == 10) tag = "R8";
                    else if (f == 2 && p == 9) tag = "R8";
                    else if (ex == MAXV) tag = "R3";
                    else tag = "R2";
                end else if (c > 0 && c < COLS - 1 && m_bad[p-1] == 0 && m_bad[p+1] == 0) begin
                    ex = (corr[p-1] + corr[p+1]) / 2;
                    tag = "R4";
                end else if (r > 0 && r < ROWS - 1 && m_bad[p-COLS] == 0 && m_bad[p+COLS] == 0) begin
                    ex = (corr[p-COLS] + corr[p+COLS]) / 2;
                    tag = "R5";
                end else begin
                    ex = lg;
                    tag = "R6";
                end
                if (i < NFR * NPIX && i < oidx) begin
                    chk(tag, $sformatf("data f%0d p%0d", f, p), odat[i], ex);
                    chk("R9", $sformatf("sof f%0d p%0d", f, p), osof[i], (p == 0) ? 1 : 0);
                    chk("R7", $sformatf("eol f%0d p%0d", f, p), oeol[i], (c == COLS - 1) ? 1 : 0);
                end
            end
            m_gain[9] = gain9;
            m_bad[0]  = bad0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule